// File: doc/BRIEF.md
# Sub-Tick Word Demultiplexer with Comma Alignment

This block sits behind a multi-gigabit receiver and its 8b/10b decoder. On every cycle of the fast word clock it takes one decoded lane word plus one control flag per byte, and it gathers a fixed number of consecutive lane words ("sub-ticks") into one wide frame word per bunch-clock period. The downstream trigger logic needs all sub-ticks of one bunch period side by side, so the frame boundary must be found and held.

The link never idles and carries no packets. Every received word is payload. A payload word equal to zero is sent as a comma word, in which every byte is the comma character with its control flag set. The block turns such words back into zero data. It also uses them as the reference for where sub-tick 0 sits. A small state machine hunts for the boundary, verifies it over several periods and declares lock. It drops lock when commas keep showing up in the wrong place. The lane width is a parameter: 16-bit lanes give eight sub-ticks per 128-bit frame, and 32-bit lanes give four.

A one-cycle valid strobe marks each frame, together with a lock flag and an error flag. The strobe keeps running while the link is unaligned; consumers ignore frames whose lock flag is low.

Top module: `stk_demux`

## Requirements
- R1: With LANE_W=16 and OUT_W=128, sub-tick s of a period appears in frame_data bits [16*s+15 : 16*s], so sub-tick 0 sits in the lowest bits and sub-tick 7 in the highest.
- R2: frame_valid is high for exactly one cycle, in the cycle after the last sub-tick of a period is sampled. It recurs every OUT_W/LANE_W cycles, and it also runs while frame_locked is low.
- R3: A comma word (every rx_ctrl bit set and every byte equal to 8'hBC) appears in the frame as an all-zero sub-tick.
- R4: While not locked, a comma word sets the sub-tick position of that word to 0.
- R5: After alignment, lock is declared at the end of the fourth consecutive period with no comma away from sub-tick 0. frame_locked is already high on that fourth period's frame.
- R6: While locked, a period with a comma at a nonzero position is counted as misaligned, and a clean period clears the count. The third consecutive misaligned period drops lock (frame_locked low on that period's frame) and the search restarts.
- R7: frame_err is high on a frame when any word of its period had rx_code_err set, or had a control flag set without being a comma word. It is low on the next frame unless that period also has such a word. A non-comma control word passes through as raw data.
- R8: With LANE_W=32 and OUT_W=128, four 32-bit sub-ticks are packed with sub-tick s in bits [32*s+31 : 32*s], with 4-byte comma words and the same alignment rules.
- R9: frame_locked changes only in cycles where frame_valid is high.
- R10: During reset, frame_valid, frame_locked and frame_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_word | input | LANE_W | Decoded lane word |
| rx_ctrl | input | LANE_W/8 | Per-byte control-character flag |
| rx_code_err | input | 1 | Decoder reports a disparity or code error on this word |
| frame_data | output | OUT_W | Packed sub-ticks of one period, sub-tick 0 lowest |
| frame_valid | output | 1 | One-cycle frame strobe |
| frame_locked | output | 1 | Frame boundary is locked |
| frame_err | output | 1 | Error seen in this frame's period |

## Verification
The bench builds two copies side by side: one with 16-bit lanes and one with 32-bit lanes, both with 128-bit frames. The small sub-tick counts of 8 and 4 let every period be compared word for word against arithmetically generated payload.

The 16-bit copy runs through 21 periods. These cover acquisition from a misaligned start and a single stray comma while locked. They also cover two consecutive misses that recover, three consecutive misses that lose lock, re-acquisition, and both error kinds. The 32-bit copy repeats acquisition, zero substitution and error marking at the other packing.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam logic [7:0] COMMA_BYTE = 8'hBC;

    typedef enum logic [1:0] {
        ALN_SEARCH = 2'd0,
        ALN_VERIFY = 2'd1,
        ALN_LOCKED = 2'd2
    } aln_state_e;

endpackage

// File: rtl/stk_char_classify.sv
// Classifies one lane word: comma detection, zero substitution, error flag.
module stk_char_classify
    import stk_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  logic [LANE_W-1:0]   word_i,
    input  logic [LANE_W/8-1:0] ctrl_i,
    input  logic                code_err_i,
    output logic [LANE_W-1:0]   word_o,
    output logic                is_comma_o,
    output logic                err_o
);
    localparam int NB = LANE_W / 8;

    logic [NB-1:0] byte_match;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign byte_match[b] = ctrl_i[b] && (word_i[b*8 +: 8] == COMMA_BYTE);
    end

    assign is_comma_o = &byte_match;
    assign err_o      = code_err_i | ((|ctrl_i) & ~is_comma_o);
    assign word_o     = is_comma_o ? '0 : word_i;

endmodule

// File: rtl/stk_align.sv
// Sub-tick counter plus search / verify / locked state machine.
module stk_align
    import stk_pkg::*;
#(
    parameter int N_SUB        = 8,
    parameter int LOCK_PERIODS = 4,
    parameter int MISS_LIMIT   = 3
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  comma_i,
    output logic [((N_SUB > 1) ? $clog2(N_SUB) : 1)-1:0] pos_o,
    output logic                                  last_o,
    output logic                                  realign_o,
    output logic                                  locked_o
);
    localparam int CW = (N_SUB > 1) ? $clog2(N_SUB) : 1;
    localparam int GW = $clog2(LOCK_PERIODS + 1);
    localparam int MW = $clog2(MISS_LIMIT + 1);
    localparam logic [CW-1:0] LAST_POS = CW'(N_SUB - 1);

    typedef struct packed {
        aln_state_e    st;
        logic [CW-1:0] cnt;
        logic [GW-1:0] good;
        logic [MW-1:0] miss;
        logic          bad;
    } aln_t;

    aln_t          aln_d, aln_q;
    logic [CW-1:0] pos;
    logic          last;
    logic          realign;

    always_comb begin
        aln_d   = aln_q;
        pos     = aln_q.cnt;
        realign = 1'b0;

        unique case (aln_q.st)
            ALN_SEARCH: begin
                if (comma_i) begin
                    pos        = '0;
                    realign    = 1'b1;
                    aln_d.st   = ALN_VERIFY;
                    aln_d.good = '0;
                end
            end
            ALN_VERIFY: begin
                if (comma_i && aln_q.cnt != '0) begin
                    pos        = '0;
                    realign    = 1'b1;
                    aln_d.good = '0;
                end
            end
            ALN_LOCKED: begin
                if (comma_i && aln_q.cnt != '0) begin
                    aln_d.bad = 1'b1;
                end
            end
            default: aln_d.st = ALN_SEARCH;
        endcase

        last      = (pos == LAST_POS);
        aln_d.cnt = last ? '0 : pos + 1'b1;

        if (last) begin
            if (aln_d.st == ALN_VERIFY) begin
                if (aln_d.good == GW'(LOCK_PERIODS - 1)) begin
                    aln_d.st   = ALN_LOCKED;
                    aln_d.good = '0;
                    aln_d.miss = '0;
                    aln_d.bad  = 1'b0;
                end else begin
                    aln_d.good = aln_d.good + 1'b1;
                end
            end else if (aln_d.st == ALN_LOCKED) begin
                if (aln_d.bad) begin
                    if (aln_d.miss == MW'(MISS_LIMIT - 1)) begin
                        aln_d.st   = ALN_SEARCH;
                        aln_d.miss = '0;
                    end else begin
                        aln_d.miss = aln_d.miss + 1'b1;
                    end
                end else begin
                    aln_d.miss = '0;
                end
                aln_d.bad = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aln_q <= '{st: ALN_SEARCH, cnt: '0, good: '0, miss: '0, bad: 1'b0};
        end else begin
            aln_q <= aln_d;
        end
    end

    assign pos_o     = pos;
    assign last_o    = last;
    assign realign_o = realign;
    assign locked_o  = (aln_d.st == ALN_LOCKED);

endmodule

// File: rtl/stk_pack.sv
// Collects sub-tick words into slots and emits the frame at period end.
module stk_pack #(
    parameter int LANE_W = 16,
    parameter int N_SUB  = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [LANE_W-1:0]                     word_i,
    input  logic [((N_SUB > 1) ? $clog2(N_SUB) : 1)-1:0] pos_i,
    input  logic                                  last_i,
    input  logic                                  realign_i,
    input  logic                                  lock_i,
    input  logic                                  err_i,
    output logic [N_SUB*LANE_W-1:0]               frame_o,
    output logic                                  valid_o,
    output logic                                  lock_o,
    output logic                                  err_o
);
    typedef struct packed {
        logic [N_SUB-1:0][LANE_W-1:0] slot;
        logic [N_SUB-1:0][LANE_W-1:0] frame;
        logic                         err_acc;
        logic                         valid;
        logic                         lock;
        logic                         err;
    } pk_t;

    pk_t  pk_d, pk_q;
    logic err_run;

    always_comb begin
        pk_d        = pk_q;
        pk_d.valid  = 1'b0;
        err_run     = (realign_i ? 1'b0 : pk_q.err_acc) | err_i;
        pk_d.slot[pos_i] = word_i;

        if (last_i) begin
            pk_d.frame   = pk_d.slot;
            pk_d.valid   = 1'b1;
            pk_d.lock    = lock_i;
            pk_d.err     = err_run;
            pk_d.err_acc = 1'b0;
        end else begin
            pk_d.err_acc = err_run;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pk_q <= '0;
        end else begin
            pk_q <= pk_d;
        end
    end

    assign frame_o = pk_q.frame;
    assign valid_o = pk_q.valid;
    assign lock_o  = pk_q.lock;
    assign err_o   = pk_q.err;

endmodule

// File: rtl/stk_demux.sv
// Top: lane word classification, alignment and frame packing.
module stk_demux #(
    parameter int LANE_W       = 16,
    parameter int OUT_W        = 128,
    parameter int LOCK_PERIODS = 4,
    parameter int MISS_LIMIT   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LANE_W-1:0]   rx_word,
    input  logic [LANE_W/8-1:0] rx_ctrl,
    input  logic                rx_code_err,
    output logic [OUT_W-1:0]    frame_data,
    output logic                frame_valid,
    output logic                frame_locked,
    output logic                frame_err
);
    localparam int N_SUB = OUT_W / LANE_W;
    localparam int CW    = (N_SUB > 1) ? $clog2(N_SUB) : 1;

    logic [LANE_W-1:0] clean_word;
    logic              is_comma;
    logic              word_err;
    logic [CW-1:0]     pos;
    logic              last;
    logic              realign;
    logic              locked;

    stk_char_classify #(.LANE_W(LANE_W)) u_classify (
        .word_i     (rx_word),
        .ctrl_i     (rx_ctrl),
        .code_err_i (rx_code_err),
        .word_o     (clean_word),
        .is_comma_o (is_comma),
        .err_o      (word_err)
    );

    stk_align #(
        .N_SUB        (N_SUB),
        .LOCK_PERIODS (LOCK_PERIODS),
        .MISS_LIMIT   (MISS_LIMIT)
    ) u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .comma_i   (is_comma),
        .pos_o     (pos),
        .last_o    (last),
        .realign_o (realign),
        .locked_o  (locked)
    );

    stk_pack #(
        .LANE_W (LANE_W),
        .N_SUB  (N_SUB)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_i    (clean_word),
        .pos_i     (pos),
        .last_i    (last),
        .realign_i (realign),
        .lock_i    (locked),
        .err_i     (word_err),
        .frame_o   (frame_data),
        .valid_o   (frame_valid),
        .lock_o    (frame_locked),
        .err_o     (frame_err)
    );

endmodule

// File: rtl/stk_demux_chk.sv
// Port-level checker bound to every stk_demux instance.
module stk_demux_chk #(
    parameter int LANE_W = 16,
    parameter int OUT_W  = 128
) (
    input logic clk,
    input logic rst_n,
    input logic rx_code_err,
    input logic frame_valid,
    input logic frame_locked,
    input logic frame_err
);
    localparam int N_SUB = OUT_W / LANE_W;
    localparam int GW    = $clog2(N_SUB + 2);

    logic [GW-1:0] gap_q;
    logic          seen_q;
    logic          plock_q;
    logic          pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q   <= '0;
            seen_q  <= 1'b0;
            plock_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            if (frame_valid) begin
                gap_q   <= GW'(1);
                plock_q <= frame_locked;
                pend_q  <= rx_code_err;
            end else begin
                gap_q  <= (gap_q == GW'(N_SUB + 1)) ? gap_q : gap_q + 1'b1;
                pend_q <= pend_q | rx_code_err;
            end
            seen_q <= seen_q | frame_valid;
        end
    end

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    assert_locked_cadence_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && seen_q && plock_q) |-> (gap_q == GW'(N_SUB)));

    assert_lock_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> $stable(frame_locked));

    assert_err_reported_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && frame_locked && pend_q) |-> frame_err);

endmodule

bind stk_demux stk_demux_chk #(.LANE_W(LANE_W), .OUT_W(OUT_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_code_err  (rx_code_err),
    .frame_valid  (frame_valid),
    .frame_locked (frame_locked),
    .frame_err    (frame_err)
);

// File: tb/stk_demux_tb_top.sv
`timescale 1ns/1ps
module stk_demux_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [15:0]  w16 = '0;
    logic [1:0]   k16 = '0;
    logic         e16 = 1'b0;
    logic [127:0] d16;
    logic         v16, l16, r16;

    logic [31:0]  w32 = '0;
    logic [3:0]   k32 = '0;
    logic         e32 = 1'b0;
    logic [127:0] d32;
    logic         v32, l32, r32;

    stk_demux #(.LANE_W(16), .OUT_W(128)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_word(w16), .rx_ctrl(k16), .rx_code_err(e16),
        .frame_data(d16), .frame_valid(v16), .frame_locked(l16), .frame_err(r16));

    stk_demux #(.LANE_W(32), .OUT_W(128)) dut32_i (
        .clk(clk), .rst_n(rst_n), .rx_word(w32), .rx_ctrl(k32), .rx_code_err(e32),
        .frame_data(d32), .frame_valid(v32), .frame_locked(l32), .frame_err(r32));

    int n_chk = 0;
    int n_fail = 0;
    logic [129:0] q16[$];
    logic [129:0] q32[$];
    logic last16 = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Frame capture and R9 check between strobes, away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            last16 = 1'b0;
        end else begin
            if (v16) begin
                q16.push_back({r16, l16, d16});
                last16 = l16;
            end else begin
                check(l16 == last16, "R9", "lock moved without strobe", 128'(l16), 128'(last16));
            end
            if (v32) q32.push_back({r32, l32, d32});
        end
    end

    function automatic int nsub(input int m);
        return (m != 0) ? 4 : 8;
    endfunction

    function automatic int nper(input int m);
        return (m != 0) ? 6 : 21;
    endfunction

    function automatic bit is_c(input int m, input int p, input int s);
        if (s == 0) return 1'b1;
        if (m == 0) return (p == 5 && s == 4) ||
                           ((p == 9 || p == 10 || p == 11 || p == 16 || p == 17 ||
                             p == 19 || p == 20) && s == 5);
        return (p == 4 && s == 2);
    endfunction

    function automatic bit is_badk(input int m, input int p, input int s);
        return (m == 0) && (p == 7) && (s == 3);
    endfunction

    function automatic bit is_cerr(input int m, input int p, input int s);
        return ((m == 0) && (p == 6) && (s == 2)) || ((m != 0) && (p == 5) && (s == 1));
    endfunction

    function automatic logic [31:0] pay(input int m, input int p, input int s);
        if (m == 0) return {16'h0000, 8'(p + 1), 8'(s + 1)};
        return {8'(p + 1), 8'(s + 1), 8'hA5, 8'(p)};
    endfunction

    function automatic bit exp_lock(input int m, input int p);
        if (m == 0) return (p >= 3 && p <= 10) || (p >= 15);
        return (p >= 3);
    endfunction

    function automatic bit exp_err(input int m, input int p);
        if (m == 0) return (p == 6) || (p == 7);
        return (p == 5);
    endfunction

    task automatic drive(input int m, input logic [31:0] d, input logic [3:0] k, input logic e);
        @(negedge clk);
        if (m == 0) begin
            w16 = d[15:0]; k16 = k[1:0]; e16 = e;
        end else begin
            w32 = d; k32 = k; e32 = e;
        end
    endtask

    task automatic run(input int m);
        int nf;
        logic [129:0] fr;
        logic [127:0] ex;
        logic [31:0]  sl;
        rst_n = 1'b0;
        w16 = '0; k16 = '0; e16 = 1'b0;
        w32 = '0; k32 = '0; e32 = 1'b0;
        repeat (4) @(negedge clk);
        check(v16 == 1'b0 && l16 == 1'b0 && r16 == 1'b0, "R10", "reset outputs (16)",
              128'({v16, l16, r16}), 128'(0));
        check(v32 == 1'b0 && l32 == 1'b0 && r32 == 1'b0, "R10", "reset outputs (32)",
              128'({v32, l32, r32}), 128'(0));
        q16.delete();
        q32.delete();
        rst_n = 1'b1;
        // misaligned lead-in words, never a comma
        for (int i = 0; i < ((m == 0) ? 2 : 1); i++) drive(m, 32'h1357_2468 + 32'(i), 4'h0, 1'b0);
        for (int p = 0; p < nper(m); p++) begin
            for (int s = 0; s < nsub(m); s++) begin
                if (is_c(m, p, s))
                    drive(m, (m == 0) ? 32'h0000_BCBC : 32'hBCBC_BCBC, (m == 0) ? 4'h3 : 4'hF, 1'b0);
                else if (is_badk(m, p, s))
                    drive(m, 32'h0000_FCFC, 4'h3, 1'b0);
                else
                    drive(m, pay(m, p, s), 4'h0, is_cerr(m, p, s));
            end
        end
        drive(m, 32'h1111_2222, 4'h0, 1'b0);
        drive(m, 32'h3333_4444, 4'h0, 1'b0);
        repeat (3) @(negedge clk);

        nf = (m == 0) ? q16.size() : q32.size();
        check(nf == nper(m), "R2", "frame count incl. unlocked periods", 128'(nf), 128'(nper(m)));
        for (int p = 0; p < nper(m) && p < nf; p++) begin
            fr = (m == 0) ? q16[p] : q32[p];
            ex = '0;
            for (int s = 0; s < nsub(m); s++) begin
                if (is_c(m, p, s))          sl = 32'h0;
                else if (is_badk(m, p, s))  sl = 32'h0000_FCFC;
                else                        sl = pay(m, p, s);
                if (m == 0) ex[s*16 +: 16] = sl[15:0];
                else        ex[s*32 +: 32] = sl;
                if (is_c(m, p, s) && s != 0)
                    check(((m == 0) ? 32'(fr[s*16 +: 16]) : fr[s*32 +: 32]) == 32'h0, "R3",
                          "comma slot not zero", (m == 0) ? 128'(fr[s*16 +: 16]) : 128'(fr[s*32 +: 32]),
                          128'(0));
            end
            check(fr[127:0] == ex, (m == 0) ? "R1 R3 R4" : "R8 R3 R4", "frame data",
                  fr[127:0], ex);
            check(fr[128] == exp_lock(m, p),
                  ((p <= 3) || (p >= 12 && p <= 15)) ? "R5" : "R6", "lock flag",
                  128'(fr[128]), 128'(exp_lock(m, p)));
            check(fr[129] == exp_err(m, p), "R7", "error flag",
                  128'(fr[129]), 128'(exp_err(m, p)));
        end
    endtask

    initial begin
        run(0);
        run(1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule